// File: doc/BRIEF.md
# Condition Code and Status Register

This block keeps a 16-bit processor status word and refreshes its two-bit condition code from the outcome of the most recent operation. The caller picks one of four ways to read that outcome: the sign of a result, the character class of a byte, a comparison of two operands, or a device status taken directly from outside. A pulse on the update strobe also captures the carry and overflow flags that the arithmetic unit supplies for that same operation. All other fields of the word hold their values.

A privileged full-word load replaces the whole register in one cycle. It is accepted only while the privileged-mode bit of the current word is set. A loaded condition code of 3 is the illegal value. It is stored unchanged, and a one-cycle flag reports it.

Bit numbering follows the word's own convention: field bit 0 is the most significant bit, `sr_o[15]`. The field layout, from `sr_o[15]` down to `sr_o[0]`, is:

- privileged mode, `sr_o[15]`
- interrupts enabled, `sr_o[14]`
- traps enabled, `sr_o[13]`
- right stack op pending, `sr_o[12]`
- overflow, `sr_o[11]`
- carry, `sr_o[10]`
- condition code, `sr_o[9:8]`
- segment number, `sr_o[7:0]`

Condition codes are greater = 0, less = 1, equal = 2 and illegal = 3.

Top module: `ccr_status_unit`

## Requirements
- R1: During synchronous reset and in the cycle after it, `sr_o` is 16'h8000 (privileged set, all else 0) and `illegal_o` is 0.
- R2: With `mode_i`=0 (sign test) and `upd_i` high, the condition code becomes 1 if `opa_i` as 16-bit two's complement is negative, 2 if zero, 0 if positive.
- R3: With `mode_i`=1 (character class) and `upd_i` high, `opa_i[7:0]` in ASCII 'A'..'Z' or 'a'..'z' gives 2, in '0'..'9' gives 0, and any other byte gives 1; `opa_i[15:8]` has no effect.
- R4: With `mode_i`=2 (compare) and `upd_i` high, signed `opa_i` < `opb_i` gives 1, equal gives 2, greater gives 0.
- R5: With `mode_i`=3 (device) and `upd_i` high, `dev_i` 0 (no response) gives 1, 1 (ready) gives 2, 2 (busy) gives 0, and the reserved value 3 gives 1.
- R6: On an update, `sr_o[11]` takes `ovf_i` and `sr_o[10]` takes `cry_i`. The new condition code and flags appear on `sr_o` one clock after the strobed edge.
- R7: Without an update or an accepted load, `sr_o` holds. An update never changes `sr_o[15:12]` or `sr_o[7:0]`.
- R8: When `ld_i` is high and `sr_o[15]` is 1, `sr_o` takes `ld_data_i` at the next edge. An accepted load takes priority over an update in the same cycle.
- R9: When `sr_o[15]` is 0, `ld_i` has no effect. An update in the same cycle is still applied.
- R10: An accepted load whose bits [9:8] are 3 stores 3 as is. `illegal_o` is then 1 for exactly the following cycle and 0 after it, unless another such load follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_i | input | 1 | Update strobe for condition code, carry, overflow |
| mode_i | input | 2 | Interpretation: 0 sign, 1 character, 2 compare, 3 device |
| opa_i | input | 16 | Result or first operand; low byte is the character |
| opb_i | input | 16 | Second operand for compare |
| dev_i | input | 2 | Device status: 0 no response, 1 ready, 2 busy, 3 reserved |
| cry_i | input | 1 | Carry of the last arithmetic operation |
| ovf_i | input | 1 | Overflow of the last arithmetic operation |
| ld_i | input | 1 | Full-word load request |
| ld_data_i | input | 16 | Word to load |
| sr_o | output | 16 | Status register |
| illegal_o | output | 1 | One-cycle flag: illegal code was loaded |

## Verification
Every result of this block is registered, so each one is due exactly one clock after the edge at which its stimulus was sampled. This holds for the condition code, the carry and overflow bits, a loaded word and the illegal-code pulse. The driver sets inputs at the falling edge and pushes the expected word and flag for the following rising edge into a queue. The monitor pops one item just after each rising edge and compares, so expectations stay aligned with that single-cycle latency. A second idle cycle after the illegal load confirms that the flag drops again.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  localparam int SR_W    = 16;
  localparam int SEG_W   = 8;
  localparam int PRIV_B  = SR_W - 1;
  localparam int INTEN_B = SR_W - 2;
  localparam int TRAP_B  = SR_W - 3;
  localparam int RSTK_B  = SR_W - 4;
  localparam int OVF_B   = SR_W - 5;
  localparam int CRY_B   = SR_W - 6;
  localparam int CC_HI   = SR_W - 7;
  localparam int CC_LO   = SR_W - 8;
  localparam logic [SR_W-1:0] SR_RST = 16'h8000;

  typedef enum logic [1:0] {
    CC_GT  = 2'd0,
    CC_LT  = 2'd1,
    CC_EQ  = 2'd2,
    CC_BAD = 2'd3
  } cc_e;

  typedef enum logic [1:0] {
    MD_SIGN = 2'd0,
    MD_CHAR = 2'd1,
    MD_CMP  = 2'd2,
    MD_DEV  = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    DV_NORESP = 2'd0,
    DV_READY  = 2'd1,
    DV_BUSY   = 2'd2,
    DV_RSVD   = 2'd3
  } dev_e;
endpackage

// File: rtl/ccr_char_class.sv
module ccr_char_class #(
  parameter int CH_W = 8
) (
  input  logic [CH_W-1:0] ch_i,
  output logic            alpha_o,
  output logic            digit_o
);
  localparam logic [CH_W-1:0] UP_LO  = CH_W'(8'h41);
  localparam logic [CH_W-1:0] UP_HI  = CH_W'(8'h5A);
  localparam logic [CH_W-1:0] LOW_LO = CH_W'(8'h61);
  localparam logic [CH_W-1:0] LOW_HI = CH_W'(8'h7A);
  localparam logic [CH_W-1:0] DIG_LO = CH_W'(8'h30);
  localparam logic [CH_W-1:0] DIG_HI = CH_W'(8'h39);

  logic in_upper, in_lower;

  always_comb begin
    in_upper = (ch_i >= UP_LO)  && (ch_i <= UP_HI);
    in_lower = (ch_i >= LOW_LO) && (ch_i <= LOW_HI);
    alpha_o  = in_upper || in_lower;
    digit_o  = (ch_i >= DIG_LO) && (ch_i <= DIG_HI);
  end
endmodule

// File: rtl/ccr_cc_eval.sv
module ccr_cc_eval
  import ccr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CH_W   = 8
) (
  input  mode_e             mode_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  dev_e              dev_i,
  output cc_e               cc_o
);
  logic              is_alpha, is_digit;
  logic [DATA_W-1:0] rhs;
  logic              lt, eq;
  cc_e               cc_arith, cc_char, cc_dev;

  ccr_char_class #(.CH_W(CH_W)) u_char (
    .ch_i    (opa_i[CH_W-1:0]),
    .alpha_o (is_alpha),
    .digit_o (is_digit)
  );

  // Sign test shares the comparator with zero as right-hand side.
  always_comb begin
    rhs = (mode_i == MD_SIGN) ? '0 : opb_i;
    lt  = $signed(opa_i) < $signed(rhs);
    eq  = (opa_i == rhs);
    if (lt)      cc_arith = CC_LT;
    else if (eq) cc_arith = CC_EQ;
    else         cc_arith = CC_GT;
  end

  always_comb begin
    if (is_alpha)      cc_char = CC_EQ;
    else if (is_digit) cc_char = CC_GT;
    else               cc_char = CC_LT;
  end

  always_comb begin
    unique case (dev_i)
      DV_READY: cc_dev = CC_EQ;
      DV_BUSY:  cc_dev = CC_GT;
      default:  cc_dev = CC_LT;
    endcase
  end

  always_comb begin
    unique case (mode_i)
      MD_CHAR: cc_o = cc_char;
      MD_DEV:  cc_o = cc_dev;
      default: cc_o = cc_arith;
    endcase
  end
endmodule

// File: rtl/ccr_sr_reg.sv
module ccr_sr_reg
  import ccr_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            upd_i,
  input  cc_e             cc_i,
  input  logic            cry_i,
  input  logic            ovf_i,
  input  logic            ld_i,
  input  logic [SR_W-1:0] ld_data_i,
  output logic [SR_W-1:0] sr_o,
  output logic            illegal_o
);
  logic [SR_W-1:0] sr_q;
  logic            ill_q;
  logic            load_ok;

  assign load_ok = ld_i && sr_q[PRIV_B];

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q  <= SR_RST;
      ill_q <= 1'b0;
    end else begin
      ill_q <= 1'b0;
      if (load_ok) begin
        sr_q  <= ld_data_i;
        ill_q <= (ld_data_i[CC_HI:CC_LO] == CC_BAD);
      end else if (upd_i) begin
        sr_q[CC_HI:CC_LO] <= cc_i;
        sr_q[OVF_B]       <= ovf_i;
        sr_q[CRY_B]       <= cry_i;
      end
    end
  end

  assign sr_o      = sr_q;
  assign illegal_o = ill_q;

  AST_UPD_CC_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (upd_i && !ld_i) |=> (sr_q[CC_HI:CC_LO] != CC_BAD)); // R2
  AST_FLAGS_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    (upd_i && !ld_i) |=> (sr_q[OVF_B] == $past(ovf_i) && sr_q[CRY_B] == $past(cry_i))); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!upd_i && !ld_i) |=> $stable(sr_q)); // R7
  AST_UPPER_HOLD: assert property (@(posedge clk) disable iff (rst)
    (upd_i && !ld_i) |=> $stable({sr_q[PRIV_B:RSTK_B], sr_q[SEG_W-1:0]})); // R7
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
    (ld_i && sr_q[PRIV_B]) |=> (sr_q == $past(ld_data_i))); // R8
  AST_UNPRIV_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (ld_i && !sr_q[PRIV_B] && !upd_i) |=> $stable(sr_q)); // R9
  AST_ILLEGAL_MATCH: assert property (@(posedge clk) disable iff (rst)
    ill_q |-> (sr_q[CC_HI:CC_LO] == CC_BAD)); // R10
endmodule

// File: rtl/ccr_status_unit.sv
module ccr_status_unit
  import ccr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CH_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_i,
  input  logic [1:0]        mode_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic [1:0]        dev_i,
  input  logic              cry_i,
  input  logic              ovf_i,
  input  logic              ld_i,
  input  logic [SR_W-1:0]   ld_data_i,
  output logic [SR_W-1:0]   sr_o,
  output logic              illegal_o
);
  cc_e cc_next;

  ccr_cc_eval #(.DATA_W(DATA_W), .CH_W(CH_W)) u_eval (
    .mode_i (mode_e'(mode_i)),
    .opa_i  (opa_i),
    .opb_i  (opb_i),
    .dev_i  (dev_e'(dev_i)),
    .cc_o   (cc_next)
  );

  ccr_sr_reg u_reg (
    .clk       (clk),
    .rst       (rst),
    .upd_i     (upd_i),
    .cc_i      (cc_next),
    .cry_i     (cry_i),
    .ovf_i     (ovf_i),
    .ld_i      (ld_i),
    .ld_data_i (ld_data_i),
    .sr_o      (sr_o),
    .illegal_o (illegal_o)
  );

  AST_CMP_EQ_CODE: assert property (@(posedge clk) disable iff (rst)
    (upd_i && !ld_i && mode_i == 2'd2 && opa_i == opb_i) |=> (sr_o[CC_HI:CC_LO] == CC_EQ)); // R4
  AST_DEV_READY: assert property (@(posedge clk) disable iff (rst)
    (upd_i && !ld_i && mode_i == 2'd3 && dev_i == 2'd1) |=> (sr_o[CC_HI:CC_LO] == CC_EQ)); // R5
endmodule

// File: tb/ccr_status_unit_bench.sv
module ccr_status_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        upd_i = 1'b0;
  logic [1:0]  mode_i = 2'd0;
  logic [15:0] opa_i = '0, opb_i = '0;
  logic [1:0]  dev_i = 2'd0;
  logic        cry_i = 1'b0, ovf_i = 1'b0, ld_i = 1'b0;
  logic [15:0] ld_data_i = '0;
  logic [15:0] sr_o;
  logic        illegal_o;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  logic [15:0] exp_sr_q[$];
  logic        exp_ill_q[$];
  string       exp_tag_q[$];

  logic [15:0] m_sr = 16'h8000;
  logic        m_ill = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ccr_status_unit u_ccr_status_unit (
    .clk(clk), .rst(rst), .upd_i(upd_i), .mode_i(mode_i), .opa_i(opa_i),
    .opb_i(opb_i), .dev_i(dev_i), .cry_i(cry_i), .ovf_i(ovf_i), .ld_i(ld_i),
    .ld_data_i(ld_data_i), .sr_o(sr_o), .illegal_o(illegal_o)
  );

  function automatic logic [1:0] cc_sign(input logic [15:0] a);
    if (a[15]) return 2'd1;
    if (a == 16'h0) return 2'd2;
    return 2'd0;
  endfunction

  function automatic logic [1:0] cc_char(input logic [7:0] c);
    if ((c >= "A" && c <= "Z") || (c >= "a" && c <= "z")) return 2'd2;
    if (c >= "0" && c <= "9") return 2'd0;
    return 2'd1;
  endfunction

  function automatic logic [1:0] cc_cmp(input logic [15:0] a, input logic [15:0] b);
    int sa, sb;
    sa = int'($signed(a));
    sb = int'($signed(b));
    if (sa < sb) return 2'd1;
    if (sa == sb) return 2'd2;
    return 2'd0;
  endfunction

  function automatic logic [1:0] cc_dev(input logic [1:0] d);
    case (d)
      2'd1: return 2'd2;
      2'd2: return 2'd0;
      default: return 2'd1;
    endcase
  endfunction

  task automatic step(input logic r, input logic u, input logic [1:0] md,
                      input logic [15:0] a, input logic [15:0] b, input logic [1:0] d,
                      input logic c, input logic o, input logic l, input logic [15:0] ld,
                      input string tag);
    logic [1:0] cc;
    @(negedge clk);
    rst = r; upd_i = u; mode_i = md; opa_i = a; opb_i = b; dev_i = d;
    cry_i = c; ovf_i = o; ld_i = l; ld_data_i = ld;
    if (r) begin
      m_sr = 16'h8000; m_ill = 1'b0;
    end else begin
      m_ill = 1'b0;
      if (l && m_sr[15]) begin
        m_sr = ld;
        m_ill = (ld[9:8] == 2'd3);
      end else if (u) begin
        case (md)
          2'd0: cc = cc_sign(a);
          2'd1: cc = cc_char(a[7:0]);
          2'd2: cc = cc_cmp(a, b);
          default: cc = cc_dev(d);
        endcase
        m_sr[9:8] = cc;
        m_sr[11] = o;
        m_sr[10] = c;
      end
    end
    exp_sr_q.push_back(m_sr);
    exp_ill_q.push_back(m_ill);
    exp_tag_q.push_back(tag);
  endtask

  task automatic upd(input logic [1:0] md, input logic [15:0] a, input logic [15:0] b,
                     input logic [1:0] d, input logic c, input logic o, input string tag);
    step(1'b0, 1'b1, md, a, b, d, c, o, 1'b0, 16'h0, tag);
  endtask

  task automatic idle(input logic [15:0] a, input string tag);
    step(1'b0, 1'b0, 2'd0, a, ~a, 2'd2, 1'b1, 1'b1, 1'b0, 16'h0, tag);
  endtask

  initial begin : monitor
    logic [15:0] es;
    logic        ei;
    string       et;
    forever begin
      @(posedge clk);
      #1;
      if (exp_sr_q.size() > 0) begin
        es = exp_sr_q.pop_front();
        ei = exp_ill_q.pop_front();
        et = exp_tag_q.pop_front();
        tests++;
        if (sr_o !== es || illegal_o !== ei) begin
          fails++;
          $display("FAIL %s: sr=%h ill=%b expected sr=%h ill=%b", et, sr_o, illegal_o, es, ei);
        end
      end
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : driver
    step(1'b1, 1'b1, 2'd0, 16'h1, 16'h0, 2'd0, 1'b1, 1'b1, 1'b1, 16'h0300, "R1 reset");
    step(1'b1, 1'b0, 2'd0, 16'h0, 16'h0, 2'd0, 1'b0, 1'b0, 1'b0, 16'h0, "R1 reset");
    idle(16'h1234, "R1 after reset");
    // sign test
    upd(2'd0, 16'h0000, 16'h0, 2'd0, 1'b0, 1'b0, "R2 zero");
    upd(2'd0, 16'h0005, 16'h0, 2'd0, 1'b1, 1'b0, "R2 positive R6 carry");
    upd(2'd0, 16'hFFFF, 16'h0, 2'd0, 1'b0, 1'b1, "R2 minus one R6 overflow");
    upd(2'd0, 16'h8000, 16'h0, 2'd0, 1'b1, 1'b1, "R2 most negative R6");
    upd(2'd0, 16'h7FFF, 16'h0, 2'd0, 1'b0, 1'b0, "R2 most positive R6 clear");
    idle(16'hFFFF, "R7 hold no update");
    idle(16'h0000, "R7 hold no update");
    // character class
    upd(2'd1, 16'h0041, 16'h0, 2'd0, 1'b0, 1'b0, "R3 A");
    upd(2'd1, 16'h005A, 16'h0, 2'd0, 1'b0, 1'b0, "R3 Z");
    upd(2'd1, 16'h0061, 16'h0, 2'd0, 1'b0, 1'b0, "R3 a");
    upd(2'd1, 16'h007A, 16'h0, 2'd0, 1'b0, 1'b0, "R3 z");
    upd(2'd1, 16'h0030, 16'h0, 2'd0, 1'b0, 1'b0, "R3 0");
    upd(2'd1, 16'h0039, 16'h0, 2'd0, 1'b0, 1'b0, "R3 9");
    upd(2'd1, 16'h0040, 16'h0, 2'd0, 1'b0, 1'b0, "R3 at sign");
    upd(2'd1, 16'h005B, 16'h0, 2'd0, 1'b0, 1'b0, "R3 bracket");
    upd(2'd1, 16'h0060, 16'h0, 2'd0, 1'b0, 1'b0, "R3 backtick");
    upd(2'd1, 16'h007B, 16'h0, 2'd0, 1'b0, 1'b0, "R3 brace");
    upd(2'd1, 16'h002F, 16'h0, 2'd0, 1'b0, 1'b0, "R3 slash");
    upd(2'd1, 16'h003A, 16'h0, 2'd0, 1'b0, 1'b0, "R3 colon");
    upd(2'd1, 16'h4130, 16'h0, 2'd0, 1'b0, 1'b0, "R3 upper byte ignored");
    upd(2'd1, 16'h30C1, 16'h0, 2'd0, 1'b0, 1'b0, "R3 high-bit byte special");
    // compare
    upd(2'd2, 16'h1234, 16'h1234, 2'd0, 1'b0, 1'b0, "R4 equal");
    upd(2'd2, 16'h0001, 16'h0002, 2'd0, 1'b0, 1'b0, "R4 less");
    upd(2'd2, 16'h0003, 16'h0002, 2'd0, 1'b0, 1'b0, "R4 greater");
    upd(2'd2, 16'h8000, 16'h0001, 2'd0, 1'b0, 1'b0, "R4 signed less");
    upd(2'd2, 16'h7FFF, 16'h8000, 2'd0, 1'b0, 1'b0, "R4 signed greater");
    // device
    upd(2'd3, 16'h0, 16'h0, 2'd0, 1'b0, 1'b0, "R5 no response");
    upd(2'd3, 16'h0, 16'h0, 2'd1, 1'b0, 1'b0, "R5 ready");
    upd(2'd3, 16'h0, 16'h0, 2'd2, 1'b0, 1'b0, "R5 busy");
    upd(2'd3, 16'h0, 16'h0, 2'd3, 1'b0, 1'b0, "R5 reserved");
    // privileged load with illegal code
    step(1'b0, 1'b0, 2'd0, 16'h0, 16'h0, 2'd0, 1'b0, 1'b0, 1'b1, 16'hC3A5, "R8 R10 load illegal code");
    idle(16'h0, "R10 flag drops");
    idle(16'h0, "R10 flag stays low");
    // load beats update
    step(1'b0, 1'b1, 2'd0, 16'h0, 16'h0, 2'd0, 1'b1, 1'b1, 1'b1, 16'h8E12, "R8 load priority");
    upd(2'd2, 16'h0001, 16'h0009, 2'd0, 1'b1, 1'b0, "R7 update keeps other fields");
    // drop privilege by load
    step(1'b0, 1'b0, 2'd0, 16'h0, 16'h0, 2'd0, 1'b0, 1'b0, 1'b1, 16'h7155, "R8 load clears privilege");
    step(1'b0, 1'b0, 2'd0, 16'h0, 16'h0, 2'd0, 1'b0, 1'b0, 1'b1, 16'hFFFF, "R9 load ignored");
    step(1'b0, 1'b1, 2'd3, 16'h0, 16'h0, 2'd2, 1'b1, 1'b1, 1'b1, 16'h8300, "R9 update still applied");
    idle(16'h0, "R9 no illegal flag");
    step(1'b1, 1'b0, 2'd0, 16'h0, 16'h0, 2'd0, 1'b0, 1'b0, 1'b0, 16'h0, "R1 second reset");
    step(1'b0, 1'b0, 2'd0, 16'h0, 16'h0, 2'd0, 1'b0, 1'b0, 1'b1, 16'h8100, "R8 load after reset");
    idle(16'h0, "R10 no flag for legal code");
    repeat (3) @(negedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule